// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block carries data both ways between an A port and a B port. Each port is split into two halves of `HALF_W` bits, nine bits each by default. Each direction has its own storage path, and that path combines a transparent latch and an edge-triggered register. Three control levels govern a direction: an active-low output enable, a latch enable and a direction clock. When the latch enable is high, the stored value tracks the input, which is transparent operation. When it is low, the stored value changes only on a rising edge of the direction clock. While that clock stays at a steady level, the value is held.

The block runs on one system clock. The direction clocks are ordinary inputs: they are sampled on the system clock, and a rising edge is found by comparing the current sample with the one before it. Outputs are registered, so every effect shows one system cycle after the inputs that cause it.

Each port is modelled as separate input data, output data and a per-half drive flag, so the block has no tri-state. The `wide` input selects the layout:
- With `wide` low, the two halves are independent transceivers, each under its own control bits.
- With `wide` high, the control bits of half 0 govern the full-width path.

Top module: `bus_xcvr`

## Requirements
- R1: With a half's A-to-B latch enable high at a system clock edge, that half of `b_out` equals that half of `a_in` as sampled at that edge, one cycle later.
- R2: With the latch enable low and the sampled direction clock at the same level (high or low) on two consecutive edges, the stored half keeps its value.
- R3: With the latch enable low, a half loads its input when the sampled direction clock is 0 at one edge and 1 at the next. A 1-to-0 change loads nothing.
- R4: `oe_ab_n[h]` low sets `b_drv[h]` to 1 one cycle later, and high clears it to 0. Output data are not masked.
- R5: The B-to-A direction obeys R1 to R4 from `b_in` to `a_out`, using `oe_ba_n`, `le_ba`, `ck_ba` and `a_drv`.
- R6: With `wide` low, half h (bits h*HALF_W up to h*HALF_W+HALF_W-1) uses only control bit h of each control vector, so one half can capture or drive while the other does not.
- R7: With `wide` high, control bit 0 of each control vector governs every half, and the higher control bits have no effect.
- R8: While `rst` is high, the stored data clear to 0 and both drive flags clear to 0. The sampled direction clock is loaded during reset, so a clock held high through the release of reset does not count as a rising edge.
- R9: When the latch enable falls, the stored half keeps the last value it took while transparent, until a later rising edge loads a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | 1: half-0 controls govern the full width; 0: independent halves |
| a_in | input | HALF_W*HALVES | Data arriving at the A port |
| a_out | output | HALF_W*HALVES | Data the A port would drive (from the B-to-A path) |
| a_drv | output | HALVES | Per-half drive flag for the A port |
| b_in | input | HALF_W*HALVES | Data arriving at the B port |
| b_out | output | HALF_W*HALVES | Data the B port would drive (from the A-to-B path) |
| b_drv | output | HALVES | Per-half drive flag for the B port |
| oe_ab_n | input | HALVES | Active-low per-half enable of the B outputs |
| le_ab | input | HALVES | Per-half A-to-B latch enable |
| ck_ab | input | HALVES | Per-half A-to-B direction clock |
| oe_ba_n | input | HALVES | Active-low per-half enable of the A outputs |
| le_ba | input | HALVES | Per-half B-to-A latch enable |
| ck_ba | input | HALVES | Per-half B-to-A direction clock |

## Verification
The latch enable falling and the direction clock rising can fall in the same system cycle. In that cycle the value that is kept must be the input sampled in that cycle, not the previous one. A switch of `wide` can also coincide with a clock edge, which changes which clock sample half 1 compares against. A long random phase toggles the latch enables, the direction clocks and `wide` independently, so both coincidences occur often. A behavioural model in the bench judges every cycle against its own per-half stored value and clock history.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Control levels that steer one half of one direction
  typedef struct packed {
    logic oe_n;  // active-low output enable
    logic le;    // latch enable (transparent when high)
    logic ck;    // direction clock level
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_ctl_route.sv
module xcvr_ctl_route
  import xcvr_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic             wide,
  input  logic [HALVES-1:0] oe_n,
  input  logic [HALVES-1:0] le,
  input  logic [HALVES-1:0] ck,
  output dir_ctl_t          ctl [HALVES]
);
  // Half 0 always uses its own bits; higher halves borrow half 0 in wide mode
  for (genvar h = 0; h < HALVES; h++) begin : g_route
    if (h == 0) begin : g_base
      always_comb begin
        ctl[h].oe_n = oe_n[0];
        ctl[h].le   = le[0];
        ctl[h].ck   = ck[0];
      end
    end else begin : g_upper
      always_comb begin
        ctl[h].oe_n = wide ? oe_n[0] : oe_n[h];
        ctl[h].le   = wide ? le[0]   : le[h];
        ctl[h].ck   = wide ? ck[0]   : ck[h];
      end
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drv
);
  logic         ck_q;
  logic [W-1:0] st_q;
  logic         drv_q;
  logic         ck_rise;

  assign ck_rise = ctl.ck & ~ck_q;

  always_ff @(posedge clk) begin
    ck_q <= ctl.ck;  // loaded in reset too: no false edge at release
    if (rst) begin
      st_q  <= '0;
      drv_q <= 1'b0;
    end else begin
      drv_q <= ~ctl.oe_n;
      if (ctl.le || ck_rise) st_q <= din;
    end
  end

  assign dout = st_q;
  assign drv  = drv_q;

  // R1
  transp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.le |=> dout == $past(din));
  // R3
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && ctl.ck && !ck_q) |=> dout == $past(din));
  // R2
  static_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && (ctl.ck == ck_q)) |=> $stable(dout));
  // R4
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.oe_n |=> drv);
  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.oe_n |=> !drv);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dout == '0 && !drv));
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 9,
  parameter int HALVES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wide,
  input  logic [HALVES-1:0]        oe_n,
  input  logic [HALVES-1:0]        le,
  input  logic [HALVES-1:0]        ck,
  input  logic [HALF_W*HALVES-1:0] din,
  output logic [HALF_W*HALVES-1:0] dout,
  output logic [HALVES-1:0]        drv
);
  dir_ctl_t ctl [HALVES];

  xcvr_ctl_route #(.HALVES(HALVES)) i_route (
    .wide (wide),
    .oe_n (oe_n),
    .le   (le),
    .ck   (ck),
    .ctl  (ctl)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_lane
    xcvr_lane #(.W(HALF_W)) i_lane (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[h]),
      .din  (din[h*HALF_W +: HALF_W]),
      .dout (dout[h*HALF_W +: HALF_W]),
      .drv  (drv[h])
    );
  end

  if (HALVES > 1) begin : g_wide_chk
    // R7
    wide_drv_chk: assert property (@(posedge clk) disable iff (rst)
      wide |=> drv[HALVES-1] == drv[0]);
    // R6
    split_oe_chk: assert property (@(posedge clk) disable iff (rst)
      (!wide && oe_n[HALVES-1] && !oe_n[0]) |=> (!drv[HALVES-1] && drv[0]));
  end
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int BUS_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic [BUS_W-1:0]  a_in,
  output logic [BUS_W-1:0]  a_out,
  output logic [HALVES-1:0] a_drv,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  b_out,
  output logic [HALVES-1:0] b_drv,
  input  logic [HALVES-1:0] oe_ab_n,
  input  logic [HALVES-1:0] le_ab,
  input  logic [HALVES-1:0] ck_ab,
  input  logic [HALVES-1:0] oe_ba_n,
  input  logic [HALVES-1:0] le_ba,
  input  logic [HALVES-1:0] ck_ba
);
  // A to B
  xcvr_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ab (
    .clk  (clk),
    .rst  (rst),
    .wide (wide),
    .oe_n (oe_ab_n),
    .le   (le_ab),
    .ck   (ck_ab),
    .din  (a_in),
    .dout (b_out),
    .drv  (b_drv)
  );

  // B to A
  xcvr_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ba (
    .clk  (clk),
    .rst  (rst),
    .wide (wide),
    .oe_n (oe_ba_n),
    .le   (le_ba),
    .ck   (ck_ba),
    .din  (b_in),
    .dout (a_out),
    .drv  (a_drv)
  );
endmodule

// File: tb/test_bus_xcvr.sv
module test_bus_xcvr;
  localparam int PERIOD = 10;
  localparam int HW = 9;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  logic clk = 1'b0;
  logic rst;
  logic wide;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [NH-1:0] a_drv, b_drv;
  logic [NH-1:0] oe_ab_n, le_ab, ck_ab, oe_ba_n, le_ba, ck_ba;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_xcvr #(.HALF_W(HW), .HALVES(NH)) i_bus_xcvr (
    .clk(clk), .rst(rst), .wide(wide),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .ck_ab(ck_ab),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ck_ba(ck_ba)
  );

  // Behavioural reference: [direction][half], direction 0 = A to B
  logic [HW-1:0] m_st  [2][NH];
  logic          m_pv  [2][NH];
  logic          m_drv [2][NH];
  bit armed = 0;

  always @(posedge clk) begin
    int c;
    logic le_x, ck_x, oe_x;
    logic [HW-1:0] d_x;
    for (int d = 0; d < 2; d++) begin
      for (int h = 0; h < NH; h++) begin
        c = wide ? 0 : h;
        le_x = (d == 0) ? le_ab[c] : le_ba[c];
        ck_x = (d == 0) ? ck_ab[c] : ck_ba[c];
        oe_x = (d == 0) ? oe_ab_n[c] : oe_ba_n[c];
        d_x  = (d == 0) ? a_in[h*HW +: HW] : b_in[h*HW +: HW];
        if (rst) begin
          m_st[d][h] = '0;
          m_drv[d][h] = 1'b0;
        end else begin
          if (le_x || (ck_x && !m_pv[d][h])) m_st[d][h] = d_x;
          m_drv[d][h] = !oe_x;
        end
        m_pv[d][h] = ck_x;
      end
    end
    armed = 1;
  end

  // Model comparison on every cycle (R1/R5 and all other rules)
  always @(negedge clk) begin
    logic [BW-1:0] eb, ea;
    logic [NH-1:0] db, da;
    if (armed) begin
      for (int h = 0; h < NH; h++) begin
        eb[h*HW +: HW] = m_st[0][h];
        ea[h*HW +: HW] = m_st[1][h];
        db[h] = m_drv[0][h];
        da[h] = m_drv[1][h];
      end
      n_chk++;
      if (b_out !== eb || b_drv !== db || a_out !== ea || a_drv !== da) begin
        n_fail++;
        $display("FAIL R1/R5 model t=%0t b_out=%h/%h b_drv=%b/%b a_out=%h/%h a_drv=%b/%b",
                 $time, b_out, eb, b_drv, db, a_out, ea, a_drv, da);
      end
    end
  end

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 60000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; wide = 0; a_in = '0; b_in = '0;
    oe_ab_n = 2'b11; le_ab = 2'b00; ck_ab = 2'b11;
    oe_ba_n = 2'b11; le_ba = 2'b00; ck_ba = 2'b11;
    cyc(); cyc();
    chk("R8 reset b_out", b_out, '0);
    chk("R8 reset a_out", a_out, '0);
    chk("R8 reset drv", {16'd0, b_drv}, '0);
    rst = 0;
    cyc();
    chk("R8 no edge at release", b_out, '0);

    oe_ab_n = 2'b00; cyc();
    chk("R4 enable", {16'd0, b_drv}, 18'd3);

    le_ab = 2'b11; a_in = 18'h2A5A5; cyc();
    chk("R1 follow", b_out, 18'h2A5A5);
    a_in = 18'h15A5A; cyc();
    chk("R1 follow 2", b_out, 18'h15A5A);

    le_ab = 2'b00; a_in = 18'h3FFFF; cyc();
    chk("R9 keep last", b_out, 18'h15A5A);
    a_in = 18'h00000; cyc();
    chk("R2 static high", b_out, 18'h15A5A);

    ck_ab = 2'b00; a_in = 18'h12345; cyc();
    chk("R3 falling ignored", b_out, 18'h15A5A);
    a_in = 18'h0ABCD; cyc();
    chk("R2 static low", b_out, 18'h15A5A);

    ck_ab = 2'b11; cyc();
    chk("R3 rising", b_out, 18'h0ABCD);
    a_in = 18'h00000; cyc();
    chk("R3 one load per edge", b_out, 18'h0ABCD);

    ck_ab = 2'b00; cyc();
    a_in = 18'h3FFFF; ck_ab = 2'b01; oe_ab_n = 2'b10; cyc();
    chk("R6 split data", b_out, 18'h0ABFF);
    chk("R6 split drive", {16'd0, b_drv}, 18'd1);

    wide = 1; ck_ab = 2'b00; cyc();
    a_in = 18'h00000; ck_ab = 2'b01; oe_ab_n = 2'b01; cyc();
    chk("R7 wide capture", b_out, 18'h00000);
    chk("R7 wide drive", {16'd0, b_drv}, 18'd0);
    a_in = 18'h3FFFF; le_ab = 2'b10; cyc();
    chk("R7 upper bits ignored", b_out, 18'h00000);

    le_ba = 2'b11; oe_ba_n = 2'b00; b_in = 18'h1C3C3; cyc();
    chk("R5 follow", a_out, 18'h1C3C3);
    chk("R5 enable", {16'd0, a_drv}, 18'd3);
    le_ba = 2'b00; ck_ba = 2'b00; b_in = 18'h00000; cyc();
    chk("R5 falling hold", a_out, 18'h1C3C3);
    ck_ba = 2'b11; cyc();
    chk("R5 rising", a_out, 18'h00000);
    oe_ba_n = 2'b11; cyc();
    chk("R5 disable", {16'd0, a_drv}, 18'd0);

    for (int i = 0; i < 3000; i++) begin
      a_in = 18'($urandom); b_in = 18'($urandom);
      le_ab = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      le_ba = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      ck_ab = 2'($urandom); ck_ba = 2'($urandom);
      oe_ab_n = 2'($urandom); oe_ba_n = 2'($urandom);
      if ($urandom % 16 == 0) wide = ~wide;
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule